// File: doc/BRIEF.md
# Selective Prefix-Code Scan Decoder

This block sits at the serial input of a scan chain. It expands a compressed test stream into fixed-width blocks. Each tester cycle may carry one compressed bit, and a valid strobe marks the cycles that do.

Every codeword opens with a flag bit:

- **Flag 1:** a short prefix-free code follows. It names one of three frequent 4-bit patterns.
- **Flag 0:** the four block bits follow exactly as they appear in the block.

When a codeword ends, the block appears on a parallel output with a one-cycle load pulse. A downstream serializer can take it from there. During the raw path, a serial-load strobe marks each data bit as it is shifted into the internal buffer. The states are the flag wait, two coded branch states and one state per raw bit, so the count grows with the number of coded blocks plus the block width.

Top module: `scan_prefix_decoder`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) clears `blockOut`, `parLoad` and `serLoad` to 0. It also returns the decoder to flag wait, so the next valid bit is read as a flag even if reset came mid-codeword.
- R2: The raw path works as follows. A valid flag 0 is followed by four valid data bits, and the first data bit received becomes `blockOut[3]` (MSB first). The last becomes `blockOut[0]`.
- R3: The coded path uses a fixed table, with bits listed in arrival order and including the flag. The table is:
  - `1,0` decodes to 4'b0010.
  - `1,1,0` decodes to 4'b0100.
  - `1,1,1` decodes to 4'b0110.
- R4: `parLoad` is high for exactly the one clock cycle that follows the edge that accepted a codeword's final bit. In that same cycle `blockOut` shows the decoded block.
- R5: `blockOut` keeps its value in every cycle without a `parLoad` pulse.
- R6: A cycle with `bitValid` low has no effect, whatever `bitIn` holds. Decoding resumes from the same point on the next valid bit.
- R7: `serLoad` is high exactly in cycles where `bitValid` is high and the presented bit is a raw data bit. It is low for flag bits, coded bits and invalid cycles.
- R8: The valid bit right after a codeword's final bit is taken as the next flag, with no idle cycle. Codewords can therefore be streamed back to back.
- R9: A coded pattern (for example 0010) sent in raw form (flag 0 then its four bits) decodes to the same block.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Tester-rate clock |
| rst | input | 1 | Synchronous reset, active high |
| bitValid | input | 1 | Qualifies `bitIn` for this cycle |
| bitIn | input | 1 | Compressed serial data |
| blockOut | output | BLK_W | Last decoded block |
| parLoad | output | 1 | One-cycle pulse: new block on `blockOut` |
| serLoad | output | 1 | Current bit is shifted into the raw buffer |

## Verification
The decoder is tried with five kinds of stimulus:

- Raw patterns whose bits differ from end to end, which show up any reversal or misplacement of bit order.
- Each of the three short codes, which separates the branch states from one another.
- Coded patterns forced through the raw path, which shows that the two paths agree.
- Streams with random invalid cycles carrying junk data, which tell a decoder that waits apart from one that samples noise.
- A long back-to-back random stream, which exposes any idle cycle or lost flag between codewords.

A reset in the middle of a raw codeword confirms that the following bit is read as a flag.

// File: rtl/scan_dec_pkg.sv
package scan_dec_pkg;

  // Strobes from the control FSM to the datapath
  typedef struct packed {
    logic       shiftBit;   // push bitIn into raw buffer
    logic       emitRaw;    // raw block complete this cycle
    logic       emitCoded;  // coded leaf reached this cycle
    logic [1:0] symSel;     // which coded symbol
  } decStrobe_t;

  localparam int NUM_CODED = 3;

  // Blocks reached through the short codes, indexed by leaf
  function automatic logic [31:0] codedPattern(input logic [1:0] sel);
    case (sel)
      2'd0:    codedPattern = 32'h2;  // 0010
      2'd1:    codedPattern = 32'h4;  // 0100
      2'd2:    codedPattern = 32'h6;  // 0110
      default: codedPattern = 32'h0;
    endcase
  endfunction

endpackage

// File: rtl/scan_dec_ctrl.sv
module scan_dec_ctrl
  import scan_dec_pkg::*;
#(
  parameter int BLK_W = 4
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       bitValid,
  input  logic       bitIn,
  output decStrobe_t strobe,
  output logic       serLoad
);

  localparam int CNT_W = (BLK_W > 2) ? $clog2(BLK_W) : 1;
  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(BLK_W - 1);

  typedef enum logic [1:0] {
    ST_FLAG,
    ST_CODE_A,
    ST_CODE_B,
    ST_RAW
  } decState_t;

  decState_t        state, nextState;
  logic [CNT_W-1:0] rawCnt, nextCnt;

  always_comb begin
    strobe    = '0;
    nextState = state;
    nextCnt   = rawCnt;
    if (bitValid) begin
      unique case (state)
        ST_FLAG: begin
          if (bitIn) begin
            nextState = ST_CODE_A;
          end else begin
            nextState = ST_RAW;
            nextCnt   = '0;
          end
        end
        ST_CODE_A: begin
          if (!bitIn) begin
            strobe.emitCoded = 1'b1;
            strobe.symSel    = 2'd0;
            nextState        = ST_FLAG;
          end else begin
            nextState = ST_CODE_B;
          end
        end
        ST_CODE_B: begin
          strobe.emitCoded = 1'b1;
          strobe.symSel    = bitIn ? 2'd2 : 2'd1;
          nextState        = ST_FLAG;
        end
        ST_RAW: begin
          strobe.shiftBit = 1'b1;
          if (rawCnt == LAST_CNT) begin
            strobe.emitRaw = 1'b1;
            nextState      = ST_FLAG;
          end else begin
            nextCnt = rawCnt + 1'b1;
          end
        end
        default: nextState = ST_FLAG;
      endcase
    end
  end

  assign serLoad = strobe.shiftBit;

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= ST_FLAG;
      rawCnt <= '0;
    end else begin
      state  <= nextState;
      rawCnt <= nextCnt;
    end
  end

  // R6: invalid cycles leave the walk untouched
  p_idle_freeze_r6: assert property (@(posedge clk) disable iff (rst)
    !bitValid |=> ($stable(state) && $stable(rawCnt)));

  // R7: the shift strobe only accompanies a valid bit
  p_ser_valid_r7: assert property (@(posedge clk) disable iff (rst)
    serLoad |-> bitValid);

  // R8: any emitted block leaves the FSM waiting for a flag
  p_emit_to_flag_r8: assert property (@(posedge clk) disable iff (rst)
    (strobe.emitRaw || strobe.emitCoded) |=> (state == ST_FLAG));

endmodule

// File: rtl/scan_dec_dpath.sv
module scan_dec_dpath
  import scan_dec_pkg::*;
#(
  parameter int BLK_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             bitIn,
  input  decStrobe_t       strobe,
  output logic [BLK_W-1:0] blockOut,
  output logic             parLoad
);

  logic [BLK_W-2:0] rawBuf;
  logic [BLK_W-1:0] shifted;

  assign shifted = {rawBuf, bitIn};

  always_ff @(posedge clk) begin
    if (rst) begin
      rawBuf   <= '0;
      blockOut <= '0;
      parLoad  <= 1'b0;
    end else begin
      if (strobe.shiftBit) rawBuf <= shifted[BLK_W-2:0];
      parLoad <= strobe.emitRaw | strobe.emitCoded;
      if (strobe.emitRaw)
        blockOut <= shifted;
      else if (strobe.emitCoded)
        blockOut <= BLK_W'(codedPattern(strobe.symSel));
    end
  end

  // R4: the shortest codeword is two bits, so pulses never touch
  p_single_pulse_r4: assert property (@(posedge clk) disable iff (rst)
    parLoad |=> !parLoad);

  // R5: the output block only moves on an emit strobe
  p_hold_block_r5: assert property (@(posedge clk) disable iff (rst)
    !(strobe.emitRaw || strobe.emitCoded) |=> $stable(blockOut));

endmodule

// File: rtl/scan_prefix_decoder.sv
module scan_prefix_decoder
  import scan_dec_pkg::*;
#(
  parameter int BLK_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             bitValid,
  input  logic             bitIn,
  output logic [BLK_W-1:0] blockOut,
  output logic             parLoad,
  output logic             serLoad
);

  decStrobe_t strobe;

  scan_dec_ctrl #(.BLK_W(BLK_W)) uCtrl (
    .clk      (clk),
    .rst      (rst),
    .bitValid (bitValid),
    .bitIn    (bitIn),
    .strobe   (strobe),
    .serLoad  (serLoad)
  );

  scan_dec_dpath #(.BLK_W(BLK_W)) uDpath (
    .clk      (clk),
    .rst      (rst),
    .bitIn    (bitIn),
    .strobe   (strobe),
    .blockOut (blockOut),
    .parLoad  (parLoad)
  );

  // R4: a pulse always follows an accepted valid bit
  p_pulse_after_bit_r4: assert property (@(posedge clk) disable iff (rst)
    parLoad |-> $past(bitValid));

endmodule

// File: tb/scan_prefix_decoder_test.sv
module scan_prefix_decoder_test;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       bitValid = 1'b0;
  logic       bitIn = 1'b0;
  logic [3:0] blockOut;
  logic       parLoad;
  logic       serLoad;

  int         checkCnt = 0;
  int         failCnt  = 0;
  logic       expPulse = 1'b0;
  logic [3:0] expBlk   = 4'h0;
  logic [3:0] lastBlk  = 4'h0;
  string      curReq   = "R1";

  always #5 clk = ~clk;

  scan_prefix_decoder #(.BLK_W(4)) uut (
    .clk      (clk),
    .rst      (rst),
    .bitValid (bitValid),
    .bitIn    (bitIn),
    .blockOut (blockOut),
    .parLoad  (parLoad),
    .serLoad  (serLoad)
  );

  task automatic check(input bit ok, input string req,
                       input logic [31:0] act, input logic [31:0] exp);
    checkCnt++;
    if (!ok) begin
      failCnt++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checkCnt, failCnt);
  endtask

  // One tester cycle: check outputs at negedge, drive, then wait for the edge
  task automatic stepBit(input logic v, input logic b, input logic expSer);
    @(negedge clk);
    if (expPulse) begin
      check(parLoad === 1'b1, "R4", 32'(parLoad), 32'd1);
      check(blockOut === expBlk, curReq, 32'(blockOut), 32'(expBlk));
      lastBlk  = expBlk;
      expPulse = 1'b0;
    end else begin
      check(parLoad === 1'b0, "R4", 32'(parLoad), 32'd0);
      check(blockOut === lastBlk, "R5", 32'(blockOut), 32'(lastBlk));
    end
    bitValid = v;
    bitIn    = b;
    #1;
    check(serLoad === expSer, "R7", 32'(serLoad), 32'(expSer));
    @(posedge clk);
  endtask

  // Encode one block (independent model of the code) and stream it
  task automatic sendCodeword(input logic [3:0] blk, input bit forceRaw, input int gapPct);
    logic [4:0] cw;
    int         len;
    bit         isRaw;
    isRaw = 1'b0;
    if (!forceRaw && blk == 4'b0010)      begin cw = 5'b00010; len = 2; end
    else if (!forceRaw && blk == 4'b0100) begin cw = 5'b00110; len = 3; end
    else if (!forceRaw && blk == 4'b0110) begin cw = 5'b00111; len = 3; end
    else begin cw = {1'b0, blk}; len = 5; isRaw = 1'b1; end
    for (int i = 0; i < len; i++) begin
      while (gapPct > 0 && $urandom_range(99) < gapPct)
        stepBit(1'b0, 1'($urandom_range(1)), 1'b0);   // R6 junk on invalid cycle
      stepBit(1'b1, cw[len-1-i], isRaw && (i > 0));
    end
    expPulse = 1'b1;
    expBlk   = blk;
  endtask

  task automatic testReset();
    curReq = "R1";
    rst = 1'b1; bitValid = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    check(blockOut === 4'h0, "R1", 32'(blockOut), 32'h0);
    check(parLoad === 1'b0, "R1", 32'(parLoad), 32'h0);
    check(serLoad === 1'b0, "R1", 32'(serLoad), 32'h0);
    rst = 1'b0;
    lastBlk = 4'h0; expPulse = 1'b0;
    // Load a non-zero block, then abandon a raw codeword with a reset
    sendCodeword(4'b1101, 1'b0, 0);
    stepBit(1'b1, 1'b0, 1'b0);   // flag 0
    stepBit(1'b1, 1'b1, 1'b1);   // first raw bit
    @(negedge clk);
    rst = 1'b1; bitValid = 1'b0;
    @(posedge clk);
    @(negedge clk);
    check(blockOut === 4'h0, "R1", 32'(blockOut), 32'h0);
    rst = 1'b0;
    lastBlk = 4'h0; expPulse = 1'b0;
    // Next bits must be read starting from a flag
    sendCodeword(4'b0010, 1'b0, 0);
    stepBit(1'b0, 1'b0, 1'b0);
  endtask

  task automatic testRaw();
    logic [3:0] pats [5] = '{4'b0000, 4'b1111, 4'b1000, 4'b0001, 4'b1011};
    curReq = "R2";
    foreach (pats[k]) sendCodeword(pats[k], 1'b0, 0);
    stepBit(1'b0, 1'b0, 1'b0);
  endtask

  task automatic testCoded();
    curReq = "R3";
    sendCodeword(4'b0010, 1'b0, 0);
    sendCodeword(4'b0100, 1'b0, 0);
    sendCodeword(4'b0110, 1'b0, 0);
    sendCodeword(4'b0010, 1'b0, 0);
    stepBit(1'b0, 1'b0, 1'b0);
  endtask

  task automatic testRawCarriesCoded();
    curReq = "R9";
    sendCodeword(4'b0010, 1'b1, 0);
    sendCodeword(4'b0110, 1'b1, 0);
    sendCodeword(4'b0100, 1'b1, 0);
    stepBit(1'b0, 1'b0, 1'b0);
  endtask

  task automatic testGaps();
    curReq = "R6";
    for (int k = 0; k < 40; k++) sendCodeword(4'($urandom_range(15)), 1'b0, 40);
    stepBit(1'b0, 1'b1, 1'b0);
  endtask

  task automatic testStream();
    curReq = "R8";
    for (int k = 0; k < 200; k++) sendCodeword(4'($urandom_range(15)), 1'b0, 0);
    stepBit(1'b0, 1'b0, 1'b0);
  endtask

  initial begin
    testReset();
    testRaw();
    testCoded();
    testRawCarriesCoded();
    testGaps();
    testStream();
    summary();
    $finish;
  end

  initial begin
    #1_000_000;
    failCnt++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

endmodule